// File: doc/BRIEF.md
# Four-Level Priority Bus Arbiter

This block arbitrates ownership of a shared backplane bus among several masters. Each master asks for the bus on one of four active-low request lines. Each line is a priority level, and a higher level beats a lower one. The arbiter watches a shared active-low busy line. It drives one active-low grant output per level and an active-low clear line, which asks the present owner to step off the bus.

Preemption is cooperative. When a request arrives above the present owner's level, the arbiter only raises clear. It then waits until the owner releases busy, and only then moves the grant. After a grant is issued, the grant stays until the new master has taken busy and withdrawn its request. An owner keeps the bus for as long as no higher request competes for it. All request and busy inputs are synchronised before use, and every output is registered.

Top module: `prio_bus_arbiter`

## Requirements
- R1: Request line i of `reqN` (active low) stands for priority level i, and level 3 is the highest. While idle with the bus free, the arbiter grants the highest requesting level by driving bit i of `grantN` low.
- R2: While the bus is owned and busy, a request at a level above the owner's level drives `clearN` low.
- R3: No grant is asserted while the synchronised busy line shows the bus in use, including the case where the bus is busy before any grant was made.
- R4: After busy is released during a clear, exactly one grant is asserted, for the highest level then requesting. On that cycle `clearN` is still low, and it returns high on the next cycle.
- R5: While the bus is owned, requests at or below the owner's level leave `clearN` high and do not assert any grant.
- R6: A grant stays low until busy is seen asserted and the granted level's request is withdrawn. The grant is then removed.
- R7: Every input passes through SYNC_STAGES flops. A request arriving at an idle arbiter with a free bus shows up on `grantN` on the SYNC_STAGES+1 rising edge after the input changes.
- R8: During and right after reset, all grant lines and `clearN` are high.
- R9: When the owner releases busy and no request is pending, the arbiter goes idle. A later request is then granted as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqN | input | NUM_LEVELS | Active-low request per priority level |
| busyN | input | 1 | Active-low shared bus-busy line |
| grantN | output | NUM_LEVELS | Active-low registered grant per level |
| clearN | output | 1 | Active-low request for the owner to release the bus |

## Verification
The bench builds the arbiter with its defaults: four levels and a two-stage synchroniser. That makes every request pattern and every owner/challenger pairing cheap to cover at random. The three-edge input-to-grant latency is pinned exactly, in one directed case. Random rounds cover several things: tie resolution among simultaneous requests, preemption by higher levels, and non-preemption by equal or lower levels. Directed cases cover a bus that is busy before any grant, and the clear-then-grant ordering.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GRANTING,
    ST_OWNED,
    ST_CLEARING
  } arbState_t;

  typedef struct packed {
    logic loadGrant;
    logic dropGrant;
    logic setClear;
    logic dropClear;
  } arbStrobe_t;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= '0;
    end else begin
      stage[0] <= rawIn;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_LEVELS = 4,
  localparam int LVL_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqS,
  input  arbStrobe_t            strobe,
  output logic                  anyReq,
  output logic                  higherPending,
  output logic                  ownerReq,
  output logic [NUM_LEVELS-1:0] grantN,
  output logic                  clearN
);
  logic [LVL_W-1:0]      winnerLvl;
  logic [LVL_W-1:0]      ownerLvl;
  logic [NUM_LEVELS-1:0] aboveOwner;
  logic [NUM_LEVELS-1:0] grantQ;
  logic                  clearQ;

  always_comb begin
    winnerLvl = '0;
    for (int i = 0; i < NUM_LEVELS; i++) begin
      if (reqS[i]) winnerLvl = LVL_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_above
    assign aboveOwner[g] = (LVL_W'(g) > ownerLvl);
  end

  assign anyReq        = |reqS;
  assign higherPending = |(reqS & aboveOwner);
  assign ownerReq      = reqS[ownerLvl];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerLvl <= '0;
      grantQ   <= '0;
      clearQ   <= 1'b0;
    end else begin
      if (strobe.loadGrant) begin
        ownerLvl <= winnerLvl;
        grantQ   <= NUM_LEVELS'(1) << winnerLvl;
      end else if (strobe.dropGrant) begin
        grantQ <= '0;
      end
      if (strobe.setClear)       clearQ <= 1'b1;
      else if (strobe.dropClear) clearQ <= 1'b0;
    end
  end

  assign grantN = ~grantQ;
  assign clearN = ~clearQ;
endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busyS,
  input  logic       anyReq,
  input  logic       higherPending,
  input  logic       ownerReq,
  output arbStrobe_t strobe
);
  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (anyReq && !busyS) begin
          strobe.loadGrant = 1'b1;
          stateNext        = ST_GRANTING;
        end
      end
      ST_GRANTING: begin
        strobe.dropClear = 1'b1;
        if (busyS && !ownerReq) begin
          strobe.dropGrant = 1'b1;
          stateNext        = ST_OWNED;
        end
      end
      ST_OWNED: begin
        if (!busyS) begin
          stateNext = ST_IDLE;
        end else if (higherPending) begin
          strobe.setClear = 1'b1;
          stateNext       = ST_CLEARING;
        end
      end
      ST_CLEARING: begin
        if (!busyS) begin
          if (anyReq) begin
            strobe.loadGrant = 1'b1;
            stateNext        = ST_GRANTING;
          end else begin
            strobe.dropClear = 1'b1;
            stateNext        = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_LEVELS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] reqN,
  input  logic                  busyN,
  output logic [NUM_LEVELS-1:0] grantN,
  output logic                  clearN
);
  localparam int SYNC_W = NUM_LEVELS + 1;

  logic [SYNC_W-1:0]     syncVec;
  logic [NUM_LEVELS-1:0] reqSync;
  logic                  busySync;
  logic                  anyReq;
  logic                  higherPending;
  logic                  ownerReq;
  arbStrobe_t            strobe;

  arb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN),
    .rawIn({~busyN, ~reqN}),
    .syncOut(syncVec)
  );

  assign reqSync  = syncVec[NUM_LEVELS-1:0];
  assign busySync = syncVec[NUM_LEVELS];

  arb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .busyS(busySync), .anyReq(anyReq),
    .higherPending(higherPending), .ownerReq(ownerReq),
    .strobe(strobe)
  );

  arb_datapath #(.NUM_LEVELS(NUM_LEVELS)) dp_i (
    .clk(clk), .rstN(rstN),
    .reqS(reqSync), .strobe(strobe),
    .anyReq(anyReq), .higherPending(higherPending), .ownerReq(ownerReq),
    .grantN(grantN), .clearN(clearN)
  );
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_LEVELS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_LEVELS-1:0] grantN,
  input logic                  clearN,
  input logic                  busyS
);
  logic anyGrant;
  assign anyGrant = |(~grantN);

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~grantN)); // R4

  AST_GRANT_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyGrant) |-> !$past(busyS)); // R3

  AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (anyGrant && !clearN) |=> clearN); // R4

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyGrant) |-> $past(busyS)); // R6

  AST_CLEAR_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clearN) |-> $past(busyS)); // R2
endmodule

bind prio_bus_arbiter arb_checker #(.NUM_LEVELS(NUM_LEVELS)) chk_i (
  .clk(clk), .rstN(rstN), .grantN(grantN), .clearN(clearN), .busyS(busySync)
);

// File: tb/prio_bus_arbiter_tb_top.sv
module prio_bus_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LEVELS     = 4;
  localparam int SETTLE     = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [LEVELS-1:0] reqN = '1;
  logic              busyN = 1'b1;
  logic [LEVELS-1:0] grantN;
  logic              clearN;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_bus_arbiter #(.NUM_LEVELS(LEVELS), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .reqN(reqN), .busyN(busyN),
    .grantN(grantN), .clearN(clearN)
  );

  function automatic int topLevel(input logic [LEVELS-1:0] p);
    int w = 0;
    for (int i = 0; i < LEVELS; i++) if (p[i]) w = i;
    return w;
  endfunction

  function automatic logic [LEVELS-1:0] grantFor(input int lvl);
    return ~(LEVELS'(1) << lvl);
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkOut(input string tag, input logic [LEVELS-1:0] expG, input logic expC);
    check(grantN === expG, {tag, " grant"}, int'(grantN), int'(expG));
    check(clearN === expC, {tag, " clear"}, int'(clearN), int'(expC));
  endtask

  task automatic releaseAll();
    reqN = '1;
    waitCyc(SETTLE);
    busyN = 1'b1;
    waitCyc(SETTLE);
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'd7341);
    waitCyc(3);
    checkOut("R8 reset", '1, 1'b1);
    rstN = 1'b1;
    waitCyc(2);
    checkOut("R8 after reset", '1, 1'b1);

    // R7 exact latency
    reqN = ~4'b0100;
    repeat (2) @(negedge clk);
    check(grantN === '1, "R7 early", int'(grantN), 'hF);
    @(negedge clk);
    check(grantN === grantFor(2), "R7 on time", int'(grantN), int'(grantFor(2)));
    busyN = 1'b0; reqN = '1;
    waitCyc(SETTLE);
    checkOut("R6 taken", '1, 1'b1);
    busyN = 1'b1;
    waitCyc(SETTLE);
    checkOut("R9 idle", '1, 1'b1);

    // R3 busy before any grant
    busyN = 1'b0; reqN = ~4'b0011;
    waitCyc(SETTLE);
    checkOut("R3 foreign busy", '1, 1'b1);
    busyN = 1'b1;
    waitCyc(SETTLE);
    checkOut("R3 freed", grantFor(1), 1'b1);
    busyN = 1'b0; reqN = ~4'b0001;
    waitCyc(SETTLE);
    checkOut("R6 lower still pending", '1, 1'b1);
    releaseAll();

    for (int it = 0; it < 40; it++) begin
      logic [LEVELS-1:0] p, q;
      int owner, win, waited;
      p = LEVELS'($urandom_range(1, 15));
      reqN = ~p;
      waitCyc(SETTLE);
      owner = topLevel(p);
      checkOut("R1 grant", grantFor(owner), 1'b1);
      busyN = 1'b0;
      p[owner] = 1'b0;
      reqN = ~p;
      waitCyc(SETTLE);
      checkOut("R6 removed R5 lower", '1, 1'b1);
      q = p | LEVELS'($urandom_range(1, 15));
      reqN = ~q;
      waitCyc(SETTLE);
      if (topLevel(q) > owner) begin
        win = topLevel(q);
        checkOut("R2 clear R3 held", '1, 1'b0);
        busyN = 1'b1;
        waited = 0;
        while (grantN === '1 && waited < 10) begin
          @(negedge clk);
          waited++;
        end
        checkOut("R4 grant with clear", grantFor(win), 1'b0);
        @(negedge clk);
        check(clearN === 1'b1, "R4 clear released", int'(clearN), 1);
        busyN = 1'b0; reqN = '1;
        waitCyc(SETTLE);
        checkOut("R6 preempt taken", '1, 1'b1);
        busyN = 1'b1;
        waitCyc(SETTLE);
      end else begin
        checkOut("R5 no preempt", '1, 1'b1);
        releaseAll();
      end
      checkOut("R9 round idle", '1, 1'b1);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule